// File: doc/BRIEF.md
# Display Identification Fetch and Checksum Engine

This block fetches a display's identification data (EDID) over an abstract byte-request port, which stands for an AUX master able to reach both the sink's register space and the identification device behind I2C-over-AUX. One `start` pulse runs the whole sequence. The engine first reads twelve capability bytes from the sink registers. It then reads the extension count of the identification data, fetches the base block and, when the count is nonzero, one extension block into an internal 256-byte buffer. The checksum of each block is built as its bytes arrive.

When the data is valid, the engine reads the sink's automated-test request register. If that register asks for an identification-read test, the engine writes the last byte of the final block back to the sink and then posts a response code. A failed transfer restarts the identification read from the extension count, up to three attempts. The verdict is success, bad checksum or I/O error, and it stays on the outputs until the next accepted start. The fetched bytes can be read back through a combinational buffer port.

Top module: `edid_fetch_engine`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low, and `busy` is high in the cycle after an accepted start. A `start` while `busy` is high has no effect on the running sequence.
- R2: At most one request is outstanding, and `req` is a one-cycle pulse. No new request is issued until `rsp_done` returns. Read requests carry `req_wdata` = 0. Writes always target sink register space (`req_i2c` = 0). Requests with `req_i2c` = 1 carry `req_dev` = 0x50.
- R3: The sequence begins with twelve reads of sink registers 0x000 to 0x00B, in increasing order. An error response during this phase ends the run with `io_err` and no retry.
- R4: Each identification attempt first reads offset 0x7E of device 0x50. Zero means bytes 0x00 to 0x7F are then read in order. Nonzero means bytes 0x00 to 0xFF are read in order.
- R5: Byte k of the fetched data is stored at buffer address k. `buf_data` shows the byte at `buf_addr` in the same cycle.
- R6: A block is valid only if its 128 bytes sum to 0 modulo 256. An invalid block ends the run at once with `bad_csum` and no further requests, and it is never retried.
- R7: Once all blocks are valid, sink register 0x218 is read. If bit 2 of that register is clear, the run ends with `ok`. If bit 2 is set, the last byte of the final block (buffer address 0x7F or 0xFF) is written to register 0x246, then 0x04 is written to register 0x260, and only then does the run end with `ok`.
- R8: An error response at any point after the capability phase restarts the attempt with the extension-count read. A third failed attempt ends the run with `io_err`.
- R9: When `done` is high, exactly one of `ok`, `bad_csum` and `io_err` is high. All four hold their values until the next accepted start. `busy` and `done` are never high together.
- R10: After reset, `busy`, `done`, `ok`, `bad_csum`, `io_err` and `req` are all low.
- R11: A `start` in the same cycle as the response that completes a run is ignored. The run's verdict is shown and held, and no new sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| req | output | 1 | Request pulse on the byte port |
| req_write | output | 1 | 1 = write, 0 = read |
| req_i2c | output | 1 | 1 = identification device over I2C, 0 = sink register space |
| req_dev | output | 7 | I2C device address (0x50 when `req_i2c`, else 0) |
| req_addr | output | REG_AW | Register address or byte offset |
| req_wdata | output | 8 | Write data (0 for reads) |
| rsp_done | input | 1 | One-cycle completion of the outstanding request |
| rsp_err | input | 1 | Error flag, valid with `rsp_done` |
| rsp_rdata | input | 8 | Read data, valid with `rsp_done` |
| buf_addr | input | log2(2*BLK_BYTES) | Buffer read address |
| buf_data | output | 8 | Buffer byte at `buf_addr` |
| busy | output | 1 | Sequence running |
| done | output | 1 | Verdict present |
| ok | output | 1 | Verdict: success |
| bad_csum | output | 1 | Verdict: block checksum failed |
| io_err | output | 1 | Verdict: transfer failed |

## Verification
The completion of a run and a fresh `start` pulse can land on the same clock edge. The bench provokes this by raising `start` in exactly the cycle in which its responder returns the final response of a run, which may be the last block byte, the test-request read or the response-code write. The check is that the verdict expected from the sink contents appears and stays, that `busy` stays low, and that no further request appears. A separate case raises `start` in the middle of a long fetch, and the request stream must match the model as if no pulse had come.

// File: rtl/edid_fetch_pkg.sv
`timescale 1ns/1ps
package edid_fetch_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CAP, PH_EXT, PH_BLK, PH_TREQ, PH_TCS, PH_TRSP
  } phase_e;

  typedef enum logic [1:0] {
    V_NONE, V_OK, V_BADSUM, V_IOERR
  } verdict_e;

  // Identification device address behind I2C-over-AUX
  localparam logic [6:0] ID_DEV = 7'h50;

  // Sink automated-test registers
  localparam logic [9:0] SINK_TEST_REQ  = 10'h218;
  localparam logic [9:0] SINK_TEST_CSUM = 10'h246;
  localparam logic [9:0] SINK_TEST_RSP  = 10'h260;
  localparam int         TEST_EDID_BIT  = 2;
  localparam logic [7:0] CSUM_WRITTEN_CODE = 8'h04;

  // Modulo-256 running sum step
  function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // A block is valid when its bytes total zero modulo 256
  function automatic logic block_sum_ok(input logic [7:0] s);
    return s == 8'h00;
  endfunction

endpackage

// File: rtl/edid_sum_acc.sv
`timescale 1ns/1ps
module edid_sum_acc
  import edid_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] byte_in,
  output logic [7:0] sum_nxt
);

  logic [7:0] sum_q;

  assign sum_nxt = csum_add(sum_q, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum_q <= 8'h00;
    else if (clr) sum_q <= 8'h00;
    else if (add) sum_q <= sum_nxt;
  end

endmodule

// File: rtl/edid_store.sv
`timescale 1ns/1ps
module edid_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/edid_fetch_engine.sv
`timescale 1ns/1ps
module edid_fetch_engine
  import edid_fetch_pkg::*;
#(
  parameter int REG_AW    = 10,
  parameter int BLK_BYTES = 128,
  parameter int CAP_BYTES = 12,
  parameter int MAX_TRIES = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  output logic                             req,
  output logic                             req_write,
  output logic                             req_i2c,
  output logic [6:0]                       req_dev,
  output logic [REG_AW-1:0]                req_addr,
  output logic [7:0]                       req_wdata,
  input  logic                             rsp_done,
  input  logic                             rsp_err,
  input  logic [7:0]                       rsp_rdata,
  input  logic [$clog2(2*BLK_BYTES)-1:0]   buf_addr,
  output logic [7:0]                       buf_data,
  output logic                             busy,
  output logic                             done,
  output logic                             ok,
  output logic                             bad_csum,
  output logic                             io_err
);

  localparam int BLK_AW    = $clog2(BLK_BYTES);
  localparam int BUF_DEPTH = 2 * BLK_BYTES;
  localparam int BUF_AW    = $clog2(BUF_DEPTH);
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam logic [BLK_AW-1:0] LAST_IDX = BLK_AW'(BLK_BYTES - 1);
  localparam logic [BLK_AW-1:0] CAP_LAST = BLK_AW'(CAP_BYTES - 1);
  localparam logic [TRY_W-1:0]  LAST_TRY = TRY_W'(MAX_TRIES - 1);
  localparam logic [REG_AW-1:0] EXT_OFS  = REG_AW'(BLK_BYTES - 2);

  phase_e              phase_q;
  verdict_e            res_q;
  logic                wait_q, busy_q, ext_q, blk_q;
  logic [BLK_AW-1:0]   idx_q;
  logic [TRY_W-1:0]    tries_q;
  logic [7:0]          last_q;

  // Named internal events
  logic              launch, rsp_take, xfer_ok, xfer_bad;
  logic              blk_byte, blk_end, sum_ok, acc_clr;
  logic [7:0]        sum_nxt;
  logic [BUF_AW-1:0] buf_wa;

  assign launch   = start & ~busy_q;
  assign rsp_take = wait_q & rsp_done;
  assign xfer_ok  = rsp_take & ~rsp_err;
  assign xfer_bad = rsp_take & rsp_err;
  assign blk_byte = xfer_ok & (phase_q == PH_BLK);
  assign blk_end  = blk_byte & (idx_q == LAST_IDX);
  assign sum_ok   = block_sum_ok(sum_nxt);
  assign acc_clr  = (xfer_ok & (phase_q == PH_EXT)) | blk_end;
  assign buf_wa   = {blk_q, idx_q};

  edid_sum_acc u_sum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(blk_byte),
    .byte_in(rsp_rdata), .sum_nxt(sum_nxt)
  );

  edid_store #(.DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .wr_en(blk_byte), .wr_addr(buf_wa), .wr_data(rsp_rdata),
    .rd_addr(buf_addr), .rd_data(buf_data)
  );

  // Request decode (Moore outputs)
  always_comb begin
    req       = busy_q & ~wait_q;
    req_write = (phase_q == PH_TCS) || (phase_q == PH_TRSP);
    req_i2c   = (phase_q == PH_EXT) || (phase_q == PH_BLK);
    req_dev   = req_i2c ? ID_DEV : 7'h00;
    req_addr  = '0;
    req_wdata = 8'h00;
    unique case (phase_q)
      PH_CAP:  req_addr = REG_AW'(idx_q);
      PH_EXT:  req_addr = EXT_OFS;
      PH_BLK:  req_addr = REG_AW'(buf_wa);
      PH_TREQ: req_addr = REG_AW'(SINK_TEST_REQ);
      PH_TCS:  begin req_addr = REG_AW'(SINK_TEST_CSUM); req_wdata = last_q; end
      PH_TRSP: begin req_addr = REG_AW'(SINK_TEST_RSP);  req_wdata = CSUM_WRITTEN_CODE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      res_q   <= V_NONE;
      wait_q  <= 1'b0;
      busy_q  <= 1'b0;
      ext_q   <= 1'b0;
      blk_q   <= 1'b0;
      idx_q   <= '0;
      tries_q <= '0;
      last_q  <= 8'h00;
    end else begin
      if (blk_end) last_q <= rsp_rdata;
      if (launch) begin
        phase_q <= PH_CAP;
        busy_q  <= 1'b1;
        res_q   <= V_NONE;
        wait_q  <= 1'b0;
        idx_q   <= '0;
        tries_q <= '0;
      end else if (req) begin
        wait_q <= 1'b1;
      end else if (xfer_bad) begin
        wait_q <= 1'b0;
        if (phase_q == PH_CAP || tries_q == LAST_TRY) begin
          phase_q <= PH_IDLE;
          busy_q  <= 1'b0;
          res_q   <= V_IOERR;
        end else begin
          tries_q <= tries_q + 1'b1;
          phase_q <= PH_EXT;
        end
      end else if (xfer_ok) begin
        wait_q <= 1'b0;
        unique case (phase_q)
          PH_CAP: begin
            if (idx_q == CAP_LAST) begin
              idx_q   <= '0;
              phase_q <= PH_EXT;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          PH_EXT: begin
            ext_q   <= (rsp_rdata != 8'h00);
            blk_q   <= 1'b0;
            idx_q   <= '0;
            phase_q <= PH_BLK;
          end
          PH_BLK: begin
            idx_q <= idx_q + 1'b1;
            if (blk_end) begin
              if (!sum_ok) begin
                phase_q <= PH_IDLE;
                busy_q  <= 1'b0;
                res_q   <= V_BADSUM;
              end else if (!blk_q && ext_q) begin
                blk_q <= 1'b1;
              end else begin
                phase_q <= PH_TREQ;
              end
            end
          end
          PH_TREQ: begin
            if (rsp_rdata[TEST_EDID_BIT]) begin
              phase_q <= PH_TCS;
            end else begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              res_q   <= V_OK;
            end
          end
          PH_TCS: phase_q <= PH_TRSP;
          PH_TRSP: begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            res_q   <= V_OK;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy     = busy_q;
  assign done     = (res_q != V_NONE);
  assign ok       = (res_q == V_OK);
  assign bad_csum = (res_q == V_BADSUM);
  assign io_err   = (res_q == V_IOERR);

endmodule

// File: rtl/edid_fetch_chk.sv
`timescale 1ns/1ps
module edid_fetch_chk #(
  parameter int MAX_TRIES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic req,
  input logic req_write,
  input logic req_i2c,
  input logic rsp_done,
  input logic rsp_err,
  input logic busy,
  input logic done,
  input logic ok,
  input logic bad_csum,
  input logic io_err,
  input logic blk_end,
  input logic sum_ok
);

  logic out_q;
  int   err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      err_cnt <= 0;
    end else begin
      if (req)           out_q <= 1'b1;
      else if (rsp_done) out_q <= 1'b0;
      if (start && !busy)                err_cnt <= 0;
      else if (rsp_done && rsp_err)      err_cnt <= err_cnt + 1;
    end
  end

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !out_q);

  assert_writes_to_sink_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_write) |-> !req_i2c);

  assert_busy_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_badsum_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !sum_ok) |=> (bad_csum && !busy));

  assert_try_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (err_cnt < MAX_TRIES));

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, bad_csum, io_err}) == 1) && !busy);

  assert_verdict_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable({ok, bad_csum, io_err})));

endmodule

bind edid_fetch_engine edid_fetch_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req(req), .req_write(req_write),
  .req_i2c(req_i2c), .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy),
  .done(done), .ok(ok), .bad_csum(bad_csum), .io_err(io_err),
  .blk_end(blk_end), .sum_ok(sum_ok)
);

// File: tb/test_edid_fetch_engine.sv
`timescale 1ns/1ps
module test_edid_fetch_engine;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start_a = 1'b0, start_b = 1'b0, start;
  logic       req, req_write, req_i2c;
  logic [6:0] req_dev;
  logic [9:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_done = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic [7:0] buf_addr = 8'h00;
  logic [7:0] buf_data;
  logic       busy, done, ok, bad_csum, io_err;

  assign start = start_a | start_b;

  edid_fetch_engine i_edid_fetch_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .req_write(req_write),
    .req_i2c(req_i2c), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .buf_addr(buf_addr), .buf_data(buf_data), .busy(busy), .done(done),
    .ok(ok), .bad_csum(bad_csum), .io_err(io_err)
  );

  // Sink model contents and reference model state
  logic [7:0]  mem [256];
  logic [7:0]  treq_val;
  int          errs[$];
  logic [19:0] expq[$];
  string       tagq[$];
  int          exp_res;   // 1 ok, 2 bad checksum, 3 io error
  int          lat = 1;
  bit          collide = 1'b0;
  int          checks = 0, fails = 0, cycles = 0;
  int          cnt = 0, nrsp = 0;
  logic        cur_i2c;
  logic [9:0]  cur_addr;
  logic [19:0] want, got;
  string       wtag;

  task automatic chk(bit cond, string tag, string what, longint act, longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_err(int n);
    foreach (errs[k]) if (errs[k] == n) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void push(bit w, bit i2c, int addr, int wd, string tag);
    expq.push_back({w, i2c, 10'(addr), 8'(wd)});
    tagq.push_back(tag);
  endfunction

  function automatic void fill(bit ext, bit bad0, bit bad1);
    for (int b = 0; b < 2; b++) begin
      int s = 0;
      for (int i = 0; i < 127; i++) mem[b*128+i] = 8'($urandom);
      if (b == 0) mem[126] = ext ? 8'($urandom_range(1, 255)) : 8'h00;
      for (int i = 0; i < 127; i++) s += mem[b*128+i];
      mem[b*128+127] = 8'(256 - (s % 256));
    end
    if (bad0) mem[127] = mem[127] ^ 8'h10;
    if (bad1) mem[255] = mem[255] ^ 8'h01;
  endfunction

  // Behavioural protocol model: expected request stream and verdict
  function automatic void build();
    int n = 0;
    expq.delete(); tagq.delete();
    for (int i = 0; i < 12; i++) begin
      push(0, 0, i, 0, "R3");
      if (is_err(n++)) begin exp_res = 3; return; end
    end
    for (int t = 0; t < 3; t++) begin
      bit fail = 1'b0;
      int nb;
      push(0, 1, 'h7E, 0, "R4");
      if (is_err(n++)) continue;
      nb = (mem[126] != 0) ? 2 : 1;
      for (int b = 0; b < nb && !fail; b++) begin
        int s = 0;
        for (int i = 0; i < 128; i++) begin
          push(0, 1, b*128+i, 0, "R4");
          if (is_err(n++)) begin fail = 1'b1; break; end
          s += mem[b*128+i];
        end
        if (!fail && (s % 256) != 0) begin exp_res = 2; return; end
      end
      if (fail) continue;
      push(0, 0, 'h218, 0, "R7");
      if (is_err(n++)) continue;
      if (treq_val[2]) begin
        push(1, 0, 'h246, mem[nb*128-1], "R7");
        if (is_err(n++)) continue;
        push(1, 0, 'h260, 4, "R7");
        if (is_err(n++)) continue;
      end
      exp_res = 1;
      return;
    end
    exp_res = 3;
  endfunction

  // Responder and per-clock request comparison
  always @(negedge clk) begin
    cycles++;
    start_b = 1'b0;
    rsp_done = 1'b0;
    rsp_err = 1'b0;
    if (req && cnt > 0) chk(1'b0, "R2", "request while one outstanding", 1, 0);
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        rsp_done = 1'b1;
        rsp_err = is_err(nrsp);
        rsp_rdata = cur_i2c ? mem[cur_addr[7:0]] :
                    (cur_addr == 10'h218) ? treq_val : cur_addr[7:0];
        nrsp++;
        if (collide && expq.size() == 0) start_b = 1'b1;
      end
    end
    if (req) begin
      got = {req_write, req_i2c, req_addr, req_wdata};
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected request", got, 0);
      end else begin
        want = expq.pop_front();
        wtag = tagq.pop_front();
        chk(got == want, wtag, "request fields", got, want);
      end
      if (req_i2c) chk(req_dev == 7'h50, "R2", "device address", req_dev, 7'h50);
      cur_i2c = req_i2c;
      cur_addr = req_addr;
      cnt = lat;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      chk(1'b0, "R1", "watchdog expired", cycles, 150000);
      summary();
    end
  end

  task automatic run(int latency, bit coll, bit mid, string vtag);
    int g = 0;
    logic [2:0] vexp;
    lat = latency;
    collide = coll;
    nrsp = 0;
    build();
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (mid) begin
      repeat (40) @(negedge clk);
      start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      chk(busy == 1'b1, "R1", "start while busy ignored", busy, 1);
    end
    while (!done && g < 20000) begin @(negedge clk); g++; end
    chk(done == 1'b1, "R9", "done reached", done, 1);
    vexp = {exp_res == 1, exp_res == 2, exp_res == 3};
    chk({ok, bad_csum, io_err} == vexp, vtag, "verdict", {ok, bad_csum, io_err}, vexp);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R2", "requests missing", expq.size(), 0);
    chk({done, busy, ok, bad_csum, io_err} == {2'b10, vexp}, coll ? "R11" : "R9",
        "verdict held", {done, busy, ok, bad_csum, io_err}, {2'b10, vexp});
    if (exp_res == 1) begin
      int nb = (mem[126] != 0) ? 256 : 128;
      for (int a = 0; a < nb; a++) begin
        buf_addr = 8'(a);
        #1;
        chk(buf_data == mem[a], "R5", "buffer byte", buf_data, mem[a]);
      end
    end
  endtask

  initial begin
    treq_val = 8'h00;
    repeat (3) @(negedge clk);
    chk({busy, done, ok, bad_csum, io_err, req} == 6'b0, "R10", "reset state",
        {busy, done, ok, bad_csum, io_err, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, req} == 3'b0, "R10", "idle after reset", {busy, done, req}, 0);

    // R4/R7: one block, no test request
    fill(0, 0, 0); treq_val = 8'h00; errs.delete();
    run(1, 0, 0, "R7");
    // R4/R7: two blocks, test request set, start mid-run (R1)
    fill(1, 0, 0); treq_val = 8'h04;
    run(2, 0, 1, "R7");
    // R7: one block with test request
    fill(0, 0, 0); treq_val = 8'hFF;
    run(3, 0, 0, "R7");
    // R6: base block bad
    fill(1, 1, 0); treq_val = 8'h04;
    run(1, 0, 0, "R6");
    // R6: extension block bad
    fill(1, 0, 1); treq_val = 8'h00;
    run(2, 0, 0, "R6");
    // R3: error in capability read
    fill(0, 0, 0); errs.delete(); errs.push_back(5);
    run(1, 0, 0, "R3");
    // R8: error in block read, second attempt passes
    fill(1, 0, 0); treq_val = 8'h04; errs.delete(); errs.push_back(53);
    run(1, 0, 1, "R8");
    // R8: error on checksum write-back, retry passes
    fill(0, 0, 0); treq_val = 8'h04; errs.delete(); errs.push_back(142);
    run(2, 0, 0, "R8");
    // R8: three failed attempts
    errs.delete(); errs.push_back(12); errs.push_back(13); errs.push_back(14);
    run(1, 0, 0, "R8");
    // R11: start coincides with final response (ok path and bad path)
    fill(1, 0, 0); treq_val = 8'h04; errs.delete();
    run(1, 1, 0, "R11");
    fill(0, 1, 0); treq_val = 8'h00;
    run(2, 1, 0, "R11");
    fill(0, 0, 0); treq_val = 8'h00;
    run(1, 1, 0, "R11");
    summary();
  end

endmodule